// File: doc/BRIEF.md
# Glitch-Free Stoppable Clock Output Gate

This block sits between a clock synthesizer's divider outputs and the pad drivers. It decides, for every output, whether the clock passes, is parked, or is released to high impedance. Three conditions are combined: a software run/stop command, a per-output stoppable mask, and a power-down request. A separate per-output enable bit can switch any output off on its own. Single-ended outputs are parked low. Differential pairs are parked with the true leg high. For each pair, drive-mode bits choose whether the legs stay driven or go to high impedance while parked.

All clock inputs are treated as levels sampled by a fast system clock `clk`. Every gate decision is taken only at a safe boundary of that output's own clock. For a single-ended output this is its falling edge. For a pair it is the falling edge of the complement leg. As a result, no output ever shows a shortened or stretched pulse, whether it is stopping or resuming. Power-down is accepted only after it has been seen high on two successive rising edges of a reference complement clock.

Top module: `clk_out_gate`

## Requirements
- R1: While reset is asserted, every single-ended output is 0, every true leg is 1, every complement leg is 0, and both output enables of every pair are 0. After reset, each output opens at its first safe boundary.
- R2: A running single-ended output equals its input clock as sampled two `clk` edges earlier. A running pair drives the true leg with that delayed value and the complement leg with its inverse, and both output enables are 1.
- R3: While `sw_run` is 0, every output whose stop-mask bit is 1 is stopped. Outputs with mask bit 0 keep running, and so do the single-ended outputs marked free-running by the parameter `SE_FREE_MASK` (default bit 3), whatever their mask bit. Setting `sw_run` to 1 resumes the stopped outputs.
- R4: `pd_req` takes effect only when it is sampled high at two consecutive rising edges of `pd_ref_clk`. A request seen at only one such edge changes no output.
- R5: Once power-down is accepted, every single-ended output is held at 0, and every pair is parked, regardless of mask and `sw_run`.
- R6: A single-ended output changes between gated and running only while its input is low. Every high pulse on the output is exactly as long as the input's high phase, and this includes the first pulse after resuming.
- R7: A pair changes between parked and running only at a rising edge of its true input, which is a falling edge of the complement. While parked, its levels are true = 1 and complement = 0. Every low phase of the true leg is a full input low phase.
- R8: A pair parked by power-down drives only its true leg (`df_t_oe` = 1, `df_c_oe` = 0) when its `df_pd_tri` bit is 0. When that bit is 1, both output enables are 0.
- R9: A pair parked by software stop keeps both legs driven (both enables 1) when `df_sw_tri` is 0. When `df_sw_tri` is 1, both enables are 0.
- R10: An output whose enable bit is 0 is stopped: single-ended outputs are held at 0 and pairs have both enables at 0. The priority between causes is disable first, then power-down, then software stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_run | input | 1 | Software command: 1 = run, 0 = stop maskable outputs |
| pd_req | input | 1 | Power-down request, already synchronous to `clk` |
| pd_ref_clk | input | 1 | Reference complement clock used to qualify `pd_req` |
| se_clk_in | input | N_SE | Ungated single-ended clock levels |
| se_en | input | N_SE | Per-output enable, 1 = enabled |
| se_stop_mask | input | N_SE | 1 = output stops under software stop |
| df_clk_in | input | N_DF | Ungated true-leg level of each pair |
| df_en | input | N_DF | Per-pair enable, 1 = enabled |
| df_stop_mask | input | N_DF | 1 = pair stops under software stop |
| df_pd_tri | input | N_DF | Power-down parking: 0 = true leg driven, 1 = both legs high impedance |
| df_sw_tri | input | 1 | Software-stop parking: 0 = legs driven, 1 = high impedance |
| se_out | output | N_SE | Gated single-ended levels |
| df_t_out | output | N_DF | Gated true-leg levels |
| df_c_out | output | N_DF | Gated complement-leg levels |
| df_t_oe | output | N_DF | True-leg output enable |
| df_c_oe | output | N_DF | Complement-leg output enable |

## Verification
The assertions assume that every input clock holds each level for at least two `clk` cycles. Under that assumption, a falling edge seen in the samples always marks a real low phase. Because of this, an output may only rise or fall when its input sampled two cycles earlier has the same level. The bench generates all input clocks as divided versions of a cycle counter, with half-periods of three to six cycles. It changes the configuration bits only between windows and drives them away from the sampling edge, so they never change in the middle of a measured pulse. Power-down pulses in the single-edge test are kept shorter than one reference period, so they can be seen at no more than one reference rising edge.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  typedef enum logic [1:0] {
    GATE_RUN    = 2'd0,
    GATE_SWSTOP = 2'd1,
    GATE_PWRDN  = 2'd2,
    GATE_OFF    = 2'd3
  } gate_cause_e;

  // Disable outranks power-down, which outranks software stop.
  function automatic gate_cause_e resolve_cause(input logic enable,
                                                input logic pd_on,
                                                input logic sw_halt);
    gate_cause_e cause;
    if (!enable)      cause = GATE_OFF;
    else if (pd_on)   cause = GATE_PWRDN;
    else if (sw_halt) cause = GATE_SWSTOP;
    else              cause = GATE_RUN;
    return cause;
  endfunction

endpackage

// File: rtl/cg_reset_sync.sv
module cg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cg_pd_qualifier.sv
module cg_pd_qualifier #(
  parameter int QUAL_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic pd_req,
  output logic pd_accepted
);
  localparam int HW = QUAL_EDGES;

  logic          ref_s_q, ref_p_q;
  logic [HW-1:0] hist_q, hist_d;
  logic          acc_q, acc_d;
  logic          ref_rise;

  always_comb begin
    ref_rise = ref_s_q & ~ref_p_q;
    hist_d   = hist_q;
    if (ref_rise) hist_d = {hist_q[HW-2:0], pd_req};
    acc_d    = &hist_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s_q <= 1'b0;
      ref_p_q <= 1'b0;
      hist_q  <= '0;
      acc_q   <= 1'b0;
    end else begin
      ref_s_q <= ref_clk;
      ref_p_q <= ref_s_q;
      hist_q  <= hist_d;
      acc_q   <= acc_d;
    end
  end

  assign pd_accepted = acc_q;
endmodule

// File: rtl/cg_se_lane.sv
module cg_se_lane
  import clk_gate_pkg::*;
#(
  parameter bit FREE_RUN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic enable,
  input  logic stop_mask,
  input  logic sw_run,
  input  logic pd_on,
  output logic gated_out
);
  logic        smp_q, prv_q;
  logic        open_q, open_d;
  logic        out_q, out_d;
  logic        eff_mask;
  logic        fall_seen;
  gate_cause_e cause_now;

  generate
    if (FREE_RUN) begin : g_free
      assign eff_mask = stop_mask & 1'b0;
    end else begin : g_stoppable
      assign eff_mask = stop_mask;
    end
  endgenerate

  always_comb begin
    fall_seen = prv_q & ~smp_q;
    cause_now = resolve_cause(enable, pd_on, ~sw_run & eff_mask);
    open_d    = open_q;
    if (fall_seen) open_d = (cause_now == GATE_RUN);
    out_d     = smp_q & open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      prv_q  <= 1'b0;
      open_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      smp_q  <= clk_in;
      prv_q  <= smp_q;
      open_q <= open_d;
      out_q  <= out_d;
    end
  end

  assign gated_out = out_q;
endmodule

// File: rtl/cg_diff_lane.sv
module cg_diff_lane
  import clk_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic enable,
  input  logic stop_mask,
  input  logic sw_run,
  input  logic sw_tri,
  input  logic pd_on,
  input  logic pd_tri,
  output logic t_out,
  output logic c_out,
  output logic t_oe,
  output logic c_oe
);
  logic        smp_q, prv_q;
  logic        cfall_seen;
  gate_cause_e cause_q, cause_d, cause_now;
  logic        t_q, c_q, toe_q, coe_q;
  logic        t_d, c_d, toe_d, coe_d;

  always_comb begin
    cfall_seen = smp_q & ~prv_q;
    cause_now  = resolve_cause(enable, pd_on, ~sw_run & stop_mask);
    cause_d    = cfall_seen ? cause_now : cause_q;
    t_d   = 1'b1;
    c_d   = 1'b0;
    toe_d = 1'b0;
    coe_d = 1'b0;
    case (cause_d)
      GATE_RUN: begin
        t_d   = smp_q;
        c_d   = ~smp_q;
        toe_d = 1'b1;
        coe_d = 1'b1;
      end
      GATE_SWSTOP: begin
        toe_d = ~sw_tri;
        coe_d = ~sw_tri;
      end
      GATE_PWRDN: begin
        toe_d = ~pd_tri;
      end
      default: begin
        toe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= 1'b0;
      prv_q   <= 1'b0;
      cause_q <= GATE_OFF;
      t_q     <= 1'b1;
      c_q     <= 1'b0;
      toe_q   <= 1'b0;
      coe_q   <= 1'b0;
    end else begin
      smp_q   <= clk_in;
      prv_q   <= smp_q;
      cause_q <= cause_d;
      t_q     <= t_d;
      c_q     <= c_d;
      toe_q   <= toe_d;
      coe_q   <= coe_d;
    end
  end

  assign t_out = t_q;
  assign c_out = c_q;
  assign t_oe  = toe_q;
  assign c_oe  = coe_q;
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int              N_SE          = 4,
  parameter int              N_DF          = 3,
  parameter logic [N_SE-1:0] SE_FREE_MASK  = 4'b1000,
  parameter int              PD_QUAL_EDGES = 2,
  parameter int              RST_STAGES    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_run,
  input  logic            pd_req,
  input  logic            pd_ref_clk,
  input  logic [N_SE-1:0] se_clk_in,
  input  logic [N_SE-1:0] se_en,
  input  logic [N_SE-1:0] se_stop_mask,
  input  logic [N_DF-1:0] df_clk_in,
  input  logic [N_DF-1:0] df_en,
  input  logic [N_DF-1:0] df_stop_mask,
  input  logic [N_DF-1:0] df_pd_tri,
  input  logic            df_sw_tri,
  output logic [N_SE-1:0] se_out,
  output logic [N_DF-1:0] df_t_out,
  output logic [N_DF-1:0] df_c_out,
  output logic [N_DF-1:0] df_t_oe,
  output logic [N_DF-1:0] df_c_oe
);
  logic rst_n_int;
  logic pd_on;

  cg_reset_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  cg_pd_qualifier #(.QUAL_EDGES(PD_QUAL_EDGES)) pd_qual_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .ref_clk     (pd_ref_clk),
    .pd_req      (pd_req),
    .pd_accepted (pd_on)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    cg_se_lane #(.FREE_RUN(SE_FREE_MASK[i])) lane_i (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .clk_in    (se_clk_in[i]),
      .enable    (se_en[i]),
      .stop_mask (se_stop_mask[i]),
      .sw_run    (sw_run),
      .pd_on     (pd_on),
      .gated_out (se_out[i])
    );
  end

  for (genvar j = 0; j < N_DF; j++) begin : g_df
    cg_diff_lane lane_i (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .clk_in    (df_clk_in[j]),
      .enable    (df_en[j]),
      .stop_mask (df_stop_mask[j]),
      .sw_run    (sw_run),
      .sw_tri    (df_sw_tri),
      .pd_on     (pd_on),
      .pd_tri    (df_pd_tri[j]),
      .t_out     (df_t_out[j]),
      .c_out     (df_c_out[j]),
      .t_oe      (df_t_oe[j]),
      .c_oe      (df_c_oe[j])
    );
  end
endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
  parameter int N_SE = 4,
  parameter int N_DF = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_SE-1:0] se_clk_in,
  input logic [N_DF-1:0] df_clk_in,
  input logic [N_SE-1:0] se_out,
  input logic [N_DF-1:0] df_t_out,
  input logic [N_DF-1:0] df_c_out,
  input logic [N_DF-1:0] df_t_oe,
  input logic [N_DF-1:0] df_c_oe
);
  for (genvar i = 0; i < N_SE; i++) begin : g_se_chk
    // R6: an output edge only follows the same input level
    p_se_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(se_out[i]) |-> $past(se_clk_in[i], 2));
    p_se_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(se_out[i]) |-> !$past(se_clk_in[i], 2));
  end

  for (genvar j = 0; j < N_DF; j++) begin : g_df_chk
    p_df_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(df_t_out[j]) |-> $past(df_clk_in[j], 2));
    p_df_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(df_t_out[j]) |-> !$past(df_clk_in[j], 2));
    p_hold_true_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !df_c_oe[j] |-> (df_t_out[j] && !df_c_out[j]));
    p_comp_needs_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
      df_c_oe[j] |-> df_t_oe[j]);
    p_legs_opposite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (df_t_oe[j] && df_c_oe[j]) |-> (df_t_out[j] != df_c_out[j]));
  end
endmodule

bind clk_out_gate clk_out_gate_chk #(.N_SE(N_SE), .N_DF(N_DF)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .se_clk_in (se_clk_in),
  .df_clk_in (df_clk_in),
  .se_out    (se_out),
  .df_t_out  (df_t_out),
  .df_c_out  (df_c_out),
  .df_t_oe   (df_t_oe),
  .df_c_oe   (df_c_oe)
);

// File: tb/clk_out_gate_tb_top.sv
module clk_out_gate_tb_top;
  localparam int N_SE = 4;
  localparam int N_DF = 3;
  localparam logic [N_SE-1:0] FREE = 4'b1000;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_run, pd_req, pd_ref_clk, df_sw_tri;
  logic [N_SE-1:0] se_clk_in, se_en, se_stop_mask, se_out;
  logic [N_DF-1:0] df_clk_in, df_en, df_stop_mask, df_pd_tri;
  logic [N_DF-1:0] df_t_out, df_c_out, df_t_oe, df_c_oe;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  bit win_on = 0;
  bit exp_pd = 0;
  string scen_tag = "";
  logic [N_SE-1:0] se_d1 = '0, se_d2 = '0;
  logic [N_DF-1:0] df_d1 = '0, df_d2 = '0;
  int  se_len [N_SE];
  bit  se_run [N_SE];
  int  df_len [N_DF];
  bit  df_run [N_DF];

  always #4 clk = ~clk;

  clk_out_gate dut_i (
    .clk(clk), .rst_n(rst_n), .sw_run(sw_run), .pd_req(pd_req),
    .pd_ref_clk(pd_ref_clk), .se_clk_in(se_clk_in), .se_en(se_en),
    .se_stop_mask(se_stop_mask), .df_clk_in(df_clk_in), .df_en(df_en),
    .df_stop_mask(df_stop_mask), .df_pd_tri(df_pd_tri), .df_sw_tri(df_sw_tri),
    .se_out(se_out), .df_t_out(df_t_out), .df_c_out(df_c_out),
    .df_t_oe(df_t_oe), .df_c_oe(df_c_oe)
  );

  function automatic int se_hp(int i);
    return 3 + i;
  endfunction

  function automatic int df_hp(int j);
    case (j)
      0: return 4;
      1: return 3;
      default: return 5;
    endcase
  endfunction

  task automatic report(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // expected pair state {t, c, t_oe, c_oe} per R2 R8 R9 R10
  function automatic logic [3:0] exp_pair(int j, output string tag);
    if (!df_en[j]) begin tag = "R10"; return 4'b1000; end
    if (exp_pd) begin tag = "R8"; return {2'b10, !df_pd_tri[j], 1'b0}; end
    if (!sw_run && df_stop_mask[j]) begin
      tag = "R9"; return {2'b10, !df_sw_tri, !df_sw_tri};
    end
    tag = "R2";
    return {df_d2[j], !df_d2[j], 2'b11};
  endfunction

  function automatic logic exp_se(int i, output string tag);
    if (!se_en[i]) begin tag = "R10"; return 1'b0; end
    if (exp_pd) begin tag = "R5"; return 1'b0; end
    if (!sw_run && se_stop_mask[i] && !FREE[i]) begin tag = "R3"; return 1'b0; end
    tag = (se_stop_mask[i] && !sw_run) ? "R3" : "R2";
    return se_d2[i];
  endfunction

  always @(negedge clk) begin
    se_d2 = se_d1; se_d1 = se_clk_in;
    df_d2 = df_d1; df_d1 = df_clk_in;
    if (win_on) begin
      for (int i = 0; i < N_SE; i++) begin
        string t; logic e;
        e = exp_se(i, t);
        if (scen_tag != "") t = scen_tag;
        report(t, $sformatf("se_out[%0d]", i), se_out[i], e);
      end
      for (int j = 0; j < N_DF; j++) begin
        string t; logic [3:0] e;
        e = exp_pair(j, t);
        if (scen_tag != "") t = scen_tag;
        report(t, $sformatf("pair[%0d] {t,c,toe,coe}", j),
               {df_t_out[j], df_c_out[j], df_t_oe[j], df_c_oe[j]}, e);
      end
    end
    if (rst_n) begin
      for (int i = 0; i < N_SE; i++) begin
        if (se_out[i]) begin
          if (!se_run[i]) begin se_run[i] = 1; se_len[i] = 0; end
          se_len[i]++;
        end else if (se_run[i]) begin
          se_run[i] = 0;
          report("R6", $sformatf("se_out[%0d] high width", i), se_len[i], se_hp(i));
        end
      end
      for (int j = 0; j < N_DF; j++) begin
        if (!df_t_out[j]) begin
          if (!df_run[j]) begin df_run[j] = 1; df_len[j] = 0; end
          df_len[j]++;
        end else if (df_run[j]) begin
          df_run[j] = 0;
          report("R7", $sformatf("df_t_out[%0d] low width", j), df_len[j], df_hp(j));
        end
      end
    end else begin
      for (int i = 0; i < N_SE; i++) se_run[i] = 0;
      for (int j = 0; j < N_DF; j++) df_run[j] = 0;
    end
    cyc++;
    for (int i = 0; i < N_SE; i++) se_clk_in[i] = ((cyc / se_hp(i)) % 2) != 0;
    for (int j = 0; j < N_DF; j++) df_clk_in[j] = ((cyc / df_hp(j)) % 2) != 0;
    pd_ref_clk = ~df_clk_in[0];
  end

  task automatic setup(logic sw, logic [N_SE-1:0] sen, logic [N_SE-1:0] smask,
                       logic [N_DF-1:0] den, logic [N_DF-1:0] dmask,
                       logic [N_DF-1:0] pdt, logic swt, logic pd);
    @(posedge clk); #2;
    sw_run = sw; se_en = sen; se_stop_mask = smask; df_en = den;
    df_stop_mask = dmask; df_pd_tri = pdt; df_sw_tri = swt; pd_req = pd; exp_pd = pd;
  endtask

  task automatic window(int settle, int len);
    repeat (settle) @(posedge clk);
    #1 win_on = 1;
    repeat (len) @(posedge clk);
    #1 win_on = 0;
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_C10C);
    rst_n = 0; sw_run = 1; pd_req = 0; df_sw_tri = 0;
    se_clk_in = '0; df_clk_in = '0; pd_ref_clk = 1;
    se_en = '1; se_stop_mask = '0; df_en = '1; df_stop_mask = '0; df_pd_tri = '0;
    repeat (6) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    report("R1", "se_out in reset", se_out, 0);
    report("R1", "df_t_out in reset", df_t_out, 3'b111);
    report("R1", "df_c_out in reset", df_c_out, 0);
    report("R1", "df oe in reset", {df_t_oe, df_c_oe}, 0);
    @(posedge clk); #2 rst_n = 1;

    setup(1, 4'hF, 4'h0, 3'h7, 3'h0, 3'h0, 0, 0); window(64, 24);           // R2
    setup(0, 4'hF, 4'hF, 3'h7, 3'h7, 3'h0, 0, 0); window(64, 24);           // R3 R9
    setup(0, 4'hF, 4'hF, 3'h7, 3'h7, 3'h0, 1, 0); window(64, 24);           // R9
    setup(0, 4'hF, 4'b0101, 3'h7, 3'b010, 3'h0, 0, 0); window(64, 24);      // R3
    setup(1, 4'hF, 4'h0, 3'h7, 3'h0, 3'h0, 0, 0); window(64, 24);           // resume R6
    setup(1, 4'hF, 4'h0, 3'h7, 3'h0, 3'b101, 0, 1); window(64, 24);         // R5 R8
    setup(0, 4'hF, 4'hF, 3'h7, 3'h7, 3'b010, 1, 1); window(64, 24);         // R5 over R3
    setup(1, 4'hF, 4'h0, 3'h7, 3'h0, 3'h0, 0, 0); window(64, 24);
    // R4: requests shorter than one reference period are never accepted
    for (int k = 0; k < 4; k++) begin
      repeat (3 + k) @(posedge clk);
      #2 pd_req = 1;
      repeat (5) @(posedge clk);
      #2 pd_req = 0;
      scen_tag = "R4";
      window(0, 40);
      scen_tag = "";
    end
    setup(0, 4'b0110, 4'hF, 3'b100, 3'h7, 3'h0, 0, 1); window(64, 24);     // R10 priority
    setup(0, 4'b0110, 4'hF, 3'b100, 3'h7, 3'h0, 0, 0); window(64, 24);     // R10
    for (int r = 0; r < 16; r++) begin
      logic [N_SE-1:0] sen; logic [N_DF-1:0] den;
      sen = ~(4'($urandom) & 4'($urandom));
      den = ~(3'($urandom) & 3'($urandom));
      setup(1'($urandom), sen, 4'($urandom), den, 3'($urandom), 3'($urandom),
            1'($urandom), ($urandom % 4) == 0);
      window(64, 24);
    end
    setup(1, 4'hF, 4'h0, 3'h7, 3'h0, 3'h0, 0, 0); window(64, 24);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule